// File: doc/BRIEF.md
# Serial Lane Power-State Controller

This block is the state machine that decides the power and operating condition of a single lane of a high-speed serial physical layer. After power comes up it moves the lane out of an off state into a deep hibernate state. From hibernate the lane wakes into low-speed operation, and it can then move on to high-speed operation. Each speed mode has its own idle state: a light "stall" idle for high-speed and a deeper "sleep" idle for low-speed. A burst always starts from the idle state of its mode and always falls back into that same idle state when it ends.

Leaving hibernate, leaving sleep and leaving stall each take a recovery time. Each of these times is a cycle count taken from its own configuration input, and the ready flag stays low while a recovery is counting. Requests to change mode or to hibernate can arrive at any time. If one arrives during a burst or during a recovery, it is held until the lane sits in an idle state. Losing power-good clears every held request and drops the lane back to the off state. The data path, line drivers and clock recovery are outside this block. It has no streaming interface, and all of its pins are plain control and status levels or pulses.

Top module: `lane_pwr_ctrl`

## Requirements
- R1: An active-low `rst_n` puts the lane in the off state at once, without waiting for a clock edge. The off state has code 0, and in it `lane_ready` is 0 and `burst_active` is 0. When `pwr_good` is sampled low at a clock edge, that edge puts the lane in the off state from any state.
- R2: From the off state, with `pwr_good` high, the next edge moves the lane to hibernate (code 1). The lane remains in hibernate until a wake request. An operating state can only be reached by passing through hibernate.
- R3: A `wake_req` pulse sampled in hibernate starts a recovery of `hib_cyc` = N cycles. The lane enters sleep (code 2) at the (N+1)th edge after the sampling edge. `lane_ready` stays 0 until then.
- R4: In sleep, a high `burst_req` starts a recovery of `sleep_cyc` = N cycles. The lane enters the low-speed burst (code 3) at the (N+1)th edge after the sampling edge. `lane_ready` is 0 while the recovery counts and 1 once the burst has begun.
- R5: In stall (code 4), a high `burst_req` starts a recovery of `stall_cyc` = N cycles. The lane enters the high-speed burst (code 5) at the (N+1)th edge after the sampling edge. The high-speed burst is entered only from stall.
- R6: When `burst_req` is low at an edge during a burst, that edge returns the lane to the idle state of the same mode: low-speed burst goes to sleep, and high-speed burst goes to stall.
- R7: A `mode_req` pulse in an idle state with no recovery running switches the lane between sleep and stall at the sampling edge. `mode_hs`=1 selects stall and `mode_hs`=0 selects sleep.
- R8: A mode or hibernate request that arrives during a burst, during a recovery or in hibernate is held. It is applied only once the lane is in an idle state. A burst never leads directly into the idle state of the other mode.
- R9: In an idle state the priorities are, from highest to lowest: hibernate request (go to hibernate at the next edge), then mode change, then burst start.
- R10: A request held when `pwr_good` falls is discarded, and it has no effect after the lane is brought up again.
- R11: `burst_active` is 1 exactly in codes 3 and 5. `lane_ready` is 1 in codes 2–5 whenever no recovery is counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply good; low forces the off state |
| wake_req | input | 1 | Pulse: leave hibernate |
| hib_req | input | 1 | Pulse: enter hibernate |
| mode_req | input | 1 | Pulse: change speed mode |
| mode_hs | input | 1 | Target of `mode_req`: 1 high-speed, 0 low-speed |
| burst_req | input | 1 | Level: burst wanted |
| hib_cyc | input | CNT_W | Hibernate exit recovery, cycles |
| sleep_cyc | input | CNT_W | Sleep exit recovery, cycles |
| stall_cyc | input | CNT_W | Stall exit recovery, cycles |
| state_o | output | 3 | Current state code |
| burst_active | output | 1 | A burst is in progress |
| lane_ready | output | 1 | Operating and not recovering |

## Verification
The hardest case to reach from the ports is a held request that lives across a state change and is then either applied or discarded. The stimulus drives a lane into a burst, pulses a mode request whose target is the other mode, and confirms that the burst persists and that the lane then steps through the idle state of its own mode into the other idle state. A second sequence raises hibernate, mode and burst requests together in sleep. It checks that hibernate wins and that the mode request survives the whole hibernate exit. A third sequence holds a request, drops power, brings the lane back to sleep and checks that it stays there.

// File: rtl/lane_pwr_pkg.sv
package lane_pwr_pkg;
  typedef enum logic [2:0] {
    PS_OFF    = 3'd0,
    PS_HIB    = 3'd1,
    PS_SLEEP  = 3'd2,
    PS_LBURST = 3'd3,
    PS_STALL  = 3'd4,
    PS_HBURST = 3'd5
  } lane_st_e;

  typedef enum logic [1:0] {
    TSEL_HIB   = 2'd0,
    TSEL_SLEEP = 2'd1,
    TSEL_STALL = 2'd2
  } tsel_e;
endpackage

// File: rtl/lane_req_hold.sv
module lane_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hib_req,
  input  logic mode_req,
  input  logic mode_hs,
  input  logic hib_take,
  input  logic mode_take,
  output logic hib_go,
  output logic mode_go,
  output logic mode_tgt_hs
);
  logic pend_hib, pend_mode, pend_hs;

  // a fresh pulse counts at once; otherwise the held copy is used
  assign hib_go      = hib_req | pend_hib;
  assign mode_go     = mode_req | pend_mode;
  assign mode_tgt_hs = mode_req ? mode_hs : pend_hs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_hib  <= 1'b0;
      pend_mode <= 1'b0;
      pend_hs   <= 1'b0;
    end else if (clr) begin
      pend_hib  <= 1'b0;
      pend_mode <= 1'b0;
      pend_hs   <= 1'b0;
    end else begin
      if (hib_take)     pend_hib <= 1'b0;
      else if (hib_req) pend_hib <= 1'b1;
      if (mode_take) pend_mode <= 1'b0;
      else if (mode_req) begin
        pend_mode <= 1'b1;
        pend_hs   <= mode_hs;
      end
    end
  end

  // R10: a power loss leaves nothing held
  p_clear_on_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!pend_hib && !pend_mode));
endmodule

// File: rtl/lane_wake_timer.sv
module lane_wake_timer
  import lane_pwr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  tsel_e            sel,
  input  logic [CNT_W-1:0] hib_cyc,
  input  logic [CNT_W-1:0] sleep_cyc,
  input  logic [CNT_W-1:0] stall_cyc,
  output logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    unique case (sel)
      TSEL_SLEEP: load_val = sleep_cyc;
      TSEL_STALL: load_val = stall_cyc;
      default:    load_val = hib_cyc;
    endcase
  end

  assign done = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (clr) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= load_val;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  // R3: the sequencer never restarts a recovery that is still counting
  p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !start);
endmodule

// File: rtl/lane_pwr_fsm.sv
module lane_pwr_fsm
  import lane_pwr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pwr_good,
  input  logic     wake_req,
  input  logic     burst_req,
  input  logic     hib_go,
  input  logic     mode_go,
  input  logic     mode_tgt_hs,
  input  logic     t_run,
  input  logic     t_done,
  output logic     t_start,
  output tsel_e    t_sel,
  output logic     hib_take,
  output logic     mode_take,
  output lane_st_e st,
  output logic     burst_active,
  output logic     lane_ready
);
  lane_st_e nxt;

  always_comb begin
    nxt       = st;
    t_start   = 1'b0;
    t_sel     = TSEL_HIB;
    hib_take  = 1'b0;
    mode_take = 1'b0;
    unique case (st)
      PS_OFF: nxt = PS_HIB;
      PS_HIB: begin
        if (t_run) begin
          if (t_done) nxt = PS_SLEEP;
        end else begin
          if (hib_go) hib_take = 1'b1;
          if (wake_req) begin
            t_start = 1'b1;
            t_sel   = TSEL_HIB;
          end
        end
      end
      PS_SLEEP: begin
        if (t_run) begin
          if (t_done) nxt = PS_LBURST;
        end else if (hib_go) begin
          hib_take = 1'b1;
          nxt      = PS_HIB;
        end else if (mode_go) begin
          mode_take = 1'b1;
          if (mode_tgt_hs) nxt = PS_STALL;
        end else if (burst_req) begin
          t_start = 1'b1;
          t_sel   = TSEL_SLEEP;
        end
      end
      PS_STALL: begin
        if (t_run) begin
          if (t_done) nxt = PS_HBURST;
        end else if (hib_go) begin
          hib_take = 1'b1;
          nxt      = PS_HIB;
        end else if (mode_go) begin
          mode_take = 1'b1;
          if (!mode_tgt_hs) nxt = PS_SLEEP;
        end else if (burst_req) begin
          t_start = 1'b1;
          t_sel   = TSEL_STALL;
        end
      end
      PS_LBURST: if (!burst_req) nxt = PS_SLEEP;
      PS_HBURST: if (!burst_req) nxt = PS_STALL;
      default:   nxt = PS_OFF;
    endcase
    if (!pwr_good) begin
      nxt       = PS_OFF;
      t_start   = 1'b0;
      hib_take  = 1'b0;
      mode_take = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PS_OFF;
    else        st <= nxt;
  end

  assign burst_active = (st == PS_LBURST) || (st == PS_HBURST);
  assign lane_ready   = ((st == PS_SLEEP) || (st == PS_STALL) || burst_active) && !t_run;

  // R6: a low-speed burst with no request left falls back to sleep
  p_ls_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_LBURST && !burst_req && pwr_good) |=> (st == PS_SLEEP));
  // R6: a high-speed burst with no request left falls back to stall
  p_hs_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_HBURST && !burst_req && pwr_good) |=> (st == PS_STALL));
endmodule

// File: rtl/lane_pwr_ctrl.sv
module lane_pwr_ctrl
  import lane_pwr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic             wake_req,
  input  logic             hib_req,
  input  logic             mode_req,
  input  logic             mode_hs,
  input  logic             burst_req,
  input  logic [CNT_W-1:0] hib_cyc,
  input  logic [CNT_W-1:0] sleep_cyc,
  input  logic [CNT_W-1:0] stall_cyc,
  output logic [2:0]       state_o,
  output logic             burst_active,
  output logic             lane_ready
);
  logic     clr;
  logic     hib_go, mode_go, mode_tgt_hs;
  logic     hib_take, mode_take;
  logic     t_start, t_run, t_done;
  tsel_e    t_sel;
  lane_st_e st;

  assign clr     = !pwr_good;
  assign state_o = st;

  lane_req_hold u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .hib_req     (hib_req),
    .mode_req    (mode_req),
    .mode_hs     (mode_hs),
    .hib_take    (hib_take),
    .mode_take   (mode_take),
    .hib_go      (hib_go),
    .mode_go     (mode_go),
    .mode_tgt_hs (mode_tgt_hs)
  );

  lane_wake_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .start     (t_start),
    .sel       (t_sel),
    .hib_cyc   (hib_cyc),
    .sleep_cyc (sleep_cyc),
    .stall_cyc (stall_cyc),
    .run       (t_run),
    .done      (t_done)
  );

  lane_pwr_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .wake_req     (wake_req),
    .burst_req    (burst_req),
    .hib_go       (hib_go),
    .mode_go      (mode_go),
    .mode_tgt_hs  (mode_tgt_hs),
    .t_run        (t_run),
    .t_done       (t_done),
    .t_start      (t_start),
    .t_sel        (t_sel),
    .hib_take     (hib_take),
    .mode_take    (mode_take),
    .st           (st),
    .burst_active (burst_active),
    .lane_ready   (lane_ready)
  );

  // R1: a supply drop sampled at an edge lands in the off state
  p_drop_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (state_o == 3'd0 && !lane_ready && !burst_active));
  // R2: off always steps into hibernate when supply is good
  p_off_to_hib_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && pwr_good) |=> (state_o == 3'd1));
  // R2: sleep is entered only from hibernate, stall or its own burst
  p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && $past(state_o) != 3'd2) |->
      ($past(state_o) == 3'd1 || $past(state_o) == 3'd4 || $past(state_o) == 3'd3));
  // R4: the lane was not ready in the cycle before a low-speed burst begins
  p_ls_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && $past(state_o) == 3'd2) |-> !$past(lane_ready));
  // R5: the high-speed burst is entered only from stall
  p_hs_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && $past(state_o) != 3'd5) |-> ($past(state_o) == 3'd4));
  // R8: a high-speed burst never leads straight into sleep
  p_burst_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5) |=> (state_o == 3'd5 || state_o == 3'd4 || state_o == 3'd0));
endmodule

// File: tb/sim_lane_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_lane_pwr_ctrl;
  localparam int CW = 8;
  localparam int NH = 5;
  localparam int NS = 3;
  localparam int NT = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0;
  logic wake_req = 1'b0, hib_req = 1'b0, mode_req = 1'b0, mode_hs = 1'b0, burst_req = 1'b0;
  logic [CW-1:0] hib_cyc = CW'(NH), sleep_cyc = CW'(NS), stall_cyc = CW'(NT);
  logic [2:0] state_o;
  logic burst_active, lane_ready;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lane_pwr_ctrl #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .wake_req(wake_req),
    .hib_req(hib_req), .mode_req(mode_req), .mode_hs(mode_hs), .burst_req(burst_req),
    .hib_cyc(hib_cyc), .sleep_cyc(sleep_cyc), .stall_cyc(stall_cyc),
    .state_o(state_o), .burst_active(burst_active), .lane_ready(lane_ready)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input int st, input int rdy, input int bst);
    chk({req, " state"}, int'(state_o), st);
    chk({req, " ready"}, int'(lane_ready), rdy);
    chk({req, " burst"}, int'(burst_active), bst);
  endtask

  task automatic t_reset;
    step(2);
    chk_all("R1 reset", 0, 0, 0);
    rst_n = 1'b1;
    step(2);
    chk_all("R1 no supply", 0, 0, 0);
  endtask

  task automatic t_power_up;
    pwr_good = 1'b1;
    step(1);
    chk_all("R2 off->hib", 1, 0, 0);
    step(4);
    chk_all("R2 hib holds", 1, 0, 0);
  endtask

  task automatic wake;
    wake_req = 1'b1;
    step(1);
    wake_req = 1'b0;
    step(NH);
    chk_all("R3 recovering", 1, 0, 0);
    step(1);
    chk_all("R3 sleep", 2, 1, 0);
  endtask

  task automatic t_ls_burst;
    burst_req = 1'b1;
    step(NS + 1);
    chk_all("R4 recovering", 2, 0, 0);
    step(1);
    chk_all("R4 ls burst r11_", 3, 1, 1);
    burst_req = 1'b0;
    step(1);
    chk_all("R6 ls end", 2, 1, 0);
  endtask

  task automatic t_mode_idle;
    mode_req = 1'b1; mode_hs = 1'b1;
    step(1);
    mode_req = 1'b0;
    chk_all("R7 to stall", 4, 1, 0);
  endtask

  task automatic t_hs_burst;
    burst_req = 1'b1;
    step(NT + 1);
    chk_all("R5 recovering", 4, 0, 0);
    step(1);
    chk_all("R5 hs burst", 5, 1, 1);
    mode_req = 1'b1; mode_hs = 1'b0;
    step(1);
    mode_req = 1'b0;
    step(3);
    chk_all("R8 held in burst", 5, 1, 1);
    burst_req = 1'b0;
    step(1);
    chk_all("R6 hs end", 4, 1, 0);
    step(1);
    chk_all("R8 applied in idle", 2, 1, 0);
  endtask

  task automatic t_priority;
    hib_req = 1'b1; mode_req = 1'b1; mode_hs = 1'b1; burst_req = 1'b1;
    step(1);
    hib_req = 1'b0; mode_req = 1'b0; burst_req = 1'b0;
    chk_all("R9 hib wins", 1, 0, 0);
    wake();
    step(1);
    chk_all("R8 mode kept over hib", 4, 1, 0);
  endtask

  task automatic t_drop;
    mode_req = 1'b1; mode_hs = 1'b0;
    step(1);
    mode_req = 1'b0;
    chk("R7 to sleep", int'(state_o), 2);
    burst_req = 1'b1;
    step(NS + 2);
    chk("R4 burst again", int'(state_o), 3);
    mode_req = 1'b1; mode_hs = 1'b1;
    step(1);
    mode_req = 1'b0;
    chk("R8 held", int'(state_o), 3);
    pwr_good = 1'b0;
    step(1);
    chk_all("R1 drop", 0, 0, 0);
    burst_req = 1'b0;
    pwr_good = 1'b1;
    step(1);
    chk("R2 back to hib", int'(state_o), 1);
    wake();
    step(3);
    chk_all("R10 request discarded", 2, 1, 0);
  endtask

  task automatic t_async;
    @(posedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk_all("R1 async reset", 0, 0, 0);
    step(1);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_power_up();
    wake();
    t_ls_burst();
    t_mode_idle();
    t_hs_burst();
    t_priority();
    t_drop();
    t_async();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule